// File: doc/BRIEF.md
# Even/Odd Parallel 8-Point DCT and IDCT Engine

This block computes a one-dimensional 8-point discrete cosine transform, forward or inverse, on signed fixed-point samples. The eight samples are folded into two 4-point halves. One half holds the symmetric terms and the other the antisymmetric terms. Two multiply-accumulate datapaths, each with four constant-coefficient lanes, work on the halves at the same time. A whole vector therefore enters as four sample pairs on four cycles and leaves as four output pairs on four cycles. This is half the cycle count of a serial single-lane engine.

Each product is rounded to fewer fractional bits before it joins its accumulator, which keeps the adders narrow. A single round-and-clamp stage at the end produces the output samples. In inverse mode an add/subtract butterfly joins the even and odd partial sums into mirrored sample pairs. The direction is chosen per vector on its first input pair. Vectors may arrive back to back with no idle cycle, and the output stream is then continuous.

Top module: `dct_eo8`

## Requirements
- R1: With `in_inv`=0, input pair k (k=0..3) carries (x[k], x[7-k]). On output pair p (p=0..3), `out_a` equals the orthonormal DCT coefficient X[2p] within ±1 of the rounded exact value.
- R2: With `in_inv`=0, `out_b` of output pair p equals X[2p+1] within ±1 of the rounded exact value.
- R3: With `in_inv`=1, input pair k carries (X[2k], X[2k+1]). Output pair p is (x[p], x[7-p]) of the orthonormal inverse DCT, within ±1 of the rounded exact value.
- R4: Every output is clamped to the signed range of OW bits, [-2^(OW-1), 2^(OW-1)-1].
- R5: The first output pair of a vector is valid in the cycle after the clock edge that follows the edge accepting its fourth pair. `out_valid` then stays high for exactly four consecutive cycles, with pairs in order p=0,1,2,3.
- R6: Vectors sent back to back produce one output pair per cycle with no gap. Each vector yields exactly one burst. Cycles with `in_valid` low do not advance the pair count, so pairs may be spread out in time.
- R7: The direction is taken from `in_inv` on a vector's first pair. Its value on the other three pairs has no effect.
- R8: A synchronous active-high `rst` drives `out_valid` low and discards any partly received vector. The next complete vector is transformed correctly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Input pair present this cycle |
| in_inv | input | 1 | 0 selects forward transform, 1 selects inverse; sampled on a vector's first pair |
| in_a | input | IW | First sample of the input pair, signed |
| in_b | input | IW | Second sample of the input pair, signed |
| out_valid | output | 1 | Output pair present this cycle |
| out_a | output | OW | First sample of the output pair, signed |
| out_b | output | OW | Second sample of the output pair, signed |

## Verification
A pair counter that slips shows as a burst at the wrong time or as misassigned coefficients. This appears in the very next burst, two to five cycles after the vector's last pair. An accumulator that is not cleared at the start of a vector carries the previous vector's value into every lane, so the outputs drift far beyond ±1. A wrong coefficient sign or index damages one specific output position. A mode latched on the wrong pair flips the result between the forward and inverse transform for that whole vector.

// File: rtl/dct_eo_pkg.sv
package dct_eo_pkg;

    localparam int COEF_W  = 12;   // coefficient width
    localparam int COEF_FB = 11;   // coefficient fraction bits

    // even-half matrix: row m = output index 2m, column n = folded input n
    function automatic logic signed [COEF_W-1:0] coef_even(input logic [1:0] m, input logic [1:0] n);
        logic signed [COEF_W-1:0] c;
        case ({m, n})
            4'h0, 4'h1, 4'h2, 4'h3: c = 12'sd724;
            4'h4: c = 12'sd946;
            4'h5: c = 12'sd392;
            4'h6: c = -12'sd392;
            4'h7: c = -12'sd946;
            4'h8: c = 12'sd724;
            4'h9: c = -12'sd724;
            4'hA: c = -12'sd724;
            4'hB: c = 12'sd724;
            4'hC: c = 12'sd392;
            4'hD: c = -12'sd946;
            4'hE: c = 12'sd946;
            default: c = -12'sd392;
        endcase
        return c;
    endfunction

    // odd-half matrix: row m = output index 2m+1, column n = folded input n
    function automatic logic signed [COEF_W-1:0] coef_odd(input logic [1:0] m, input logic [1:0] n);
        logic signed [COEF_W-1:0] c;
        case ({m, n})
            4'h0: c = 12'sd1004;
            4'h1: c = 12'sd851;
            4'h2: c = 12'sd569;
            4'h3: c = 12'sd200;
            4'h4: c = 12'sd851;
            4'h5: c = -12'sd200;
            4'h6: c = -12'sd1004;
            4'h7: c = -12'sd569;
            4'h8: c = 12'sd569;
            4'h9: c = -12'sd1004;
            4'hA: c = 12'sd200;
            4'hB: c = 12'sd851;
            4'hC: c = 12'sd200;
            4'hD: c = -12'sd569;
            4'hE: c = 12'sd851;
            default: c = -12'sd1004;
        endcase
        return c;
    endfunction

endpackage

// File: rtl/dct_eo_butterfly.sv
module dct_eo_butterfly #(
    parameter int IW = 9
) (
    input  logic                 inv,
    input  logic signed [IW-1:0] a,
    input  logic signed [IW-1:0] b,
    output logic signed [IW:0]   op_e,
    output logic signed [IW:0]   op_o
);
    logic signed [IW:0] ax, bx;

    assign ax = {a[IW-1], a};
    assign bx = {b[IW-1], b};

    // forward: fold into sum and difference; inverse: pass the pair through
    assign op_e = inv ? ax : ax + bx;
    assign op_o = inv ? bx : ax - bx;
endmodule

// File: rtl/dct_eo_mac.sv
module dct_eo_mac #(
    parameter int OPW = 10,
    parameter int CW  = 12,
    parameter int RB  = 4,
    parameter int AW  = 21
) (
    input  logic signed [OPW-1:0] op,
    input  logic signed [CW-1:0]  coef,
    input  logic signed [AW-1:0]  acc,
    input  logic                  clear,
    output logic signed [AW-1:0]  acc_nx
);
    localparam int PW = OPW + CW;

    logic signed [PW-1:0] prod, prod_r, half;
    logic signed [AW-1:0] base;

    assign half   = PW'(1) <<< (RB - 1);
    assign prod   = op * coef;
    // drop RB fraction bits, round to nearest, before accumulation
    assign prod_r = (prod + half) >>> RB;
    assign base   = clear ? '0 : acc;
    assign acc_nx = base + AW'(prod_r);
endmodule

// File: rtl/dct_eo_fmt.sv
module dct_eo_fmt #(
    parameter int SW = 22,
    parameter int SH = 7,
    parameter int OW = 12
) (
    input  logic signed [SW-1:0] v,
    output logic signed [OW-1:0] y
);
    localparam logic signed [SW-1:0] MAXV = SW'((64'sd1 <<< (OW - 1)) - 64'sd1);
    localparam logic signed [SW-1:0] MINV = -MAXV - SW'(1);

    logic signed [SW-1:0] half, r;

    assign half = SW'(1) <<< (SH - 1);
    assign r    = (v + half) >>> SH;

    always_comb begin
        if (r > MAXV)      y = MAXV[OW-1:0];
        else if (r < MINV) y = MINV[OW-1:0];
        else               y = OW'(r);
    end
endmodule

// File: rtl/dct_eo8.sv
module dct_eo8
    import dct_eo_pkg::*;
#(
    parameter int IW = 9,
    parameter int OW = 12,
    parameter int RB = 4
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 in_valid,
    input  logic                 in_inv,
    input  logic signed [IW-1:0] in_a,
    input  logic signed [IW-1:0] in_b,
    output logic                 out_valid,
    output logic signed [OW-1:0] out_a,
    output logic signed [OW-1:0] out_b
);
    localparam int CW  = COEF_W;
    localparam int OPW = IW + 1;
    localparam int PW  = OPW + CW;
    localparam int QW  = PW - RB;
    localparam int AW  = QW + 3;
    localparam int SW  = AW + 1;
    localparam int SH  = COEF_FB - RB;
    localparam int NL  = 4;

    typedef struct packed {
        logic [1:0]                  phase;
        logic                        vmode;
        logic                        s1_valid;
        logic [1:0]                  s1_phase;
        logic                        s1_inv;
        logic signed [OPW-1:0]       s1_e;
        logic signed [OPW-1:0]       s1_o;
        logic [NL-1:0][AW-1:0]       acc_e;
        logic [NL-1:0][AW-1:0]       acc_o;
        logic                        out_valid;
        logic [1:0]                  out_idx;
        logic [NL-1:0][OW-1:0]       hold_a;
        logic [NL-1:0][OW-1:0]       hold_b;
    } state_t;

    state_t q, d;

    logic                  cur_inv, last_pair;
    logic signed [OPW-1:0] bf_e, bf_o;
    logic signed [CW-1:0]  ce [NL];
    logic signed [CW-1:0]  co [NL];
    logic signed [AW-1:0]  acc_e_nx [NL];
    logic signed [AW-1:0]  acc_o_nx [NL];
    logic signed [SW-1:0]  sum_a [NL];
    logic signed [SW-1:0]  sum_b [NL];
    logic signed [OW-1:0]  fmt_a [NL];
    logic signed [OW-1:0]  fmt_b [NL];

    // direction is fixed by the first pair of each vector
    assign cur_inv   = (q.phase == 2'd0) ? in_inv : q.vmode;
    assign last_pair = q.s1_valid && (q.s1_phase == 2'd3);

    dct_eo_butterfly #(.IW(IW)) u_bfly (
        .inv  (cur_inv),
        .a    (in_a),
        .b    (in_b),
        .op_e (bf_e),
        .op_o (bf_o)
    );

    for (genvar j = 0; j < NL; j++) begin : g_lane
        logic signed [SW-1:0] ex, ox;

        // forward: lane j is output j, phase picks the column; inverse: transposed
        assign ce[j] = q.s1_inv ? coef_even(q.s1_phase, 2'(j)) : coef_even(2'(j), q.s1_phase);
        assign co[j] = q.s1_inv ? coef_odd(q.s1_phase, 2'(j))  : coef_odd(2'(j), q.s1_phase);

        dct_eo_mac #(.OPW(OPW), .CW(CW), .RB(RB), .AW(AW)) u_mac_e (
            .op     (q.s1_e),
            .coef   (ce[j]),
            .acc    (q.acc_e[j]),
            .clear  (q.s1_phase == 2'd0),
            .acc_nx (acc_e_nx[j])
        );

        dct_eo_mac #(.OPW(OPW), .CW(CW), .RB(RB), .AW(AW)) u_mac_o (
            .op     (q.s1_o),
            .coef   (co[j]),
            .acc    (q.acc_o[j]),
            .clear  (q.s1_phase == 2'd0),
            .acc_nx (acc_o_nx[j])
        );

        assign ex = {acc_e_nx[j][AW-1], acc_e_nx[j]};
        assign ox = {acc_o_nx[j][AW-1], acc_o_nx[j]};

        // inverse recombination butterfly: (e+o, e-o) gives mirrored samples
        assign sum_a[j] = q.s1_inv ? ex + ox : ex;
        assign sum_b[j] = q.s1_inv ? ex - ox : ox;

        dct_eo_fmt #(.SW(SW), .SH(SH), .OW(OW)) u_fmt_a (.v(sum_a[j]), .y(fmt_a[j]));
        dct_eo_fmt #(.SW(SW), .SH(SH), .OW(OW)) u_fmt_b (.v(sum_b[j]), .y(fmt_b[j]));
    end

    always_comb begin
        d = q;

        if (in_valid) begin
            d.phase = q.phase + 2'd1;
            if (q.phase == 2'd0) d.vmode = in_inv;
        end

        d.s1_valid = in_valid;
        if (in_valid) begin
            d.s1_phase = q.phase;
            d.s1_inv   = cur_inv;
            d.s1_e     = bf_e;
            d.s1_o     = bf_o;
        end

        if (q.s1_valid) begin
            for (int j = 0; j < NL; j++) begin
                d.acc_e[j] = acc_e_nx[j];
                d.acc_o[j] = acc_o_nx[j];
            end
        end

        if (last_pair) begin
            d.out_valid = 1'b1;
            d.out_idx   = 2'd0;
            for (int j = 0; j < NL; j++) begin
                d.hold_a[j] = fmt_a[j];
                d.hold_b[j] = fmt_b[j];
            end
        end else if (q.out_valid) begin
            if (q.out_idx == 2'd3) d.out_valid = 1'b0;
            else                   d.out_idx   = q.out_idx + 2'd1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) q <= '0;
        else     q <= d;
    end

    assign out_valid = q.out_valid;
    assign out_a     = q.hold_a[q.out_idx];
    assign out_b     = q.hold_b[q.out_idx];

    AST_BURST_FOUR: assert property (@(posedge clk) disable iff (rst)
        $rose(out_valid) |=> out_valid ##1 out_valid ##1 out_valid); // R5
    AST_LAST_PAIR_OUT: assert property (@(posedge clk) disable iff (rst)
        last_pair |=> (out_valid && q.out_idx == 2'd0)); // R5
    AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (rst)
        $rose(out_valid) |-> $past(last_pair)); // R6
    AST_BURST_END: assert property (@(posedge clk) disable iff (rst)
        (out_valid && q.out_idx == 2'd3 && !last_pair) |=> !out_valid); // R6
    AST_MODE_HELD: assert property (@(posedge clk) disable iff (rst)
        (in_valid && q.phase != 2'd0) |=> q.vmode == $past(q.vmode)); // R7
endmodule

// File: tb/sim_dct_eo8.sv
module sim_dct_eo8;
    localparam int IW   = 9;
    localparam int OW   = 12;
    localparam int OWS  = 9;
    localparam int NEXP = 4096;
    localparam real PI  = 3.14159265358979323846;

    logic clk = 1'b0;
    logic rst, in_valid, in_inv;
    logic signed [IW-1:0] in_a, in_b;
    logic out_valid, s_valid;
    logic signed [OW-1:0]  out_a, out_b;
    logic signed [OWS-1:0] s_a, s_b;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    real ea [NEXP];
    real eb [NEXP];
    bit  em [NEXP];
    int  wr = 0;
    int  rd0 = 0;
    int  rd1 = 0;
    logic [31:0] lcg = 32'h1234_5678;

    always #10 clk = ~clk;

    dct_eo8 #(.IW(IW), .OW(OW), .RB(4)) u0 (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_inv(in_inv),
        .in_a(in_a), .in_b(in_b),
        .out_valid(out_valid), .out_a(out_a), .out_b(out_b)
    );

    dct_eo8 #(.IW(IW), .OW(OWS), .RB(4)) u1 (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_inv(in_inv),
        .in_a(in_a), .in_b(in_b),
        .out_valid(s_valid), .out_a(s_a), .out_b(s_b)
    );

    function automatic int rnd(input real r);
        if (r >= 0.0) return $rtoi(r + 0.5);
        return -$rtoi(-r + 0.5);
    endfunction

    function automatic int clampw(input int v, input int w);
        int hi = (1 << (w - 1)) - 1;
        int lo = -(1 << (w - 1));
        if (v > hi) return hi;
        if (v < lo) return lo;
        return v;
    endfunction

    task automatic chk_near(input string req, input int act, input int exp);
        int diff = act - exp;
        checks++;
        if (diff > 1 || diff < -1) begin
            errors++;
            $display("FAIL %s act=%0d exp=%0d", req, act, exp);
        end
    endtask

    task automatic chk_eq(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s act=%0d exp=%0d", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
    endtask

    // exact reference for one vector; v holds time samples (forward) or coefficients (inverse)
    task automatic push_exp(input bit inv, input int v[8]);
        real y [8];
        for (int k = 0; k < 8; k++) begin
            real acc = 0.0;
            for (int n = 0; n < 8; n++) begin
                real ck;
                if (inv) begin
                    ck = (n == 0) ? 1.0 / $sqrt(2.0) : 1.0;
                    acc += ck / 2.0 * v[n] * $cos((2.0 * k + 1.0) * n * PI / 16.0);
                end else begin
                    ck = (k == 0) ? 1.0 / $sqrt(2.0) : 1.0;
                    acc += ck / 2.0 * v[n] * $cos((2.0 * n + 1.0) * k * PI / 16.0);
                end
            end
            y[k] = acc;
        end
        for (int p = 0; p < 4; p++) begin
            ea[wr] = inv ? y[p]     : y[2 * p];
            eb[wr] = inv ? y[7 - p] : y[2 * p + 1];
            em[wr] = inv;
            wr++;
        end
    endtask

    // called just after a rising edge; returns just after the edge that took pair 3
    task automatic send_vec(input bit inv, input int v[8], input bit gaps, input bit flip);
        push_exp(inv, v);
        for (int k = 0; k < 4; k++) begin
            in_valid = 1'b1;
            in_inv   = (flip && k > 0) ? ~inv : inv;
            in_a     = IW'(inv ? v[2 * k]     : v[k]);
            in_b     = IW'(inv ? v[2 * k + 1] : v[7 - k]);
            @(posedge clk); #1;
            if (gaps && k < 3) begin
                in_valid = 1'b0;
                in_a     = '0;
                in_b     = '0;
                @(posedge clk); #1;
            end
        end
        in_valid = 1'b0;
    endtask

    always @(negedge clk) begin
        if (!rst && out_valid) begin
            if (rd0 >= wr) begin
                errors++; checks++;
                $display("FAIL R6 act=extra_pair exp=none");
            end else begin
                if (em[rd0]) begin
                    chk_near("R3", int'(out_a), rnd(ea[rd0]));
                    chk_near("R3", int'(out_b), rnd(eb[rd0]));
                end else begin
                    chk_near("R1", int'(out_a), rnd(ea[rd0]));
                    chk_near("R2", int'(out_b), rnd(eb[rd0]));
                end
                rd0++;
            end
        end
        if (!rst && s_valid) begin
            if (rd1 >= wr) begin
                errors++; checks++;
                $display("FAIL R6 act=extra_pair exp=none");
            end else begin
                chk_near("R4", int'(s_a), clampw(rnd(ea[rd1]), OWS));
                chk_near("R4", int'(s_b), clampw(rnd(eb[rd1]), OWS));
                rd1++;
            end
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL R6 act=hung exp=finished");
            summary();
            $finish;
        end
    end

    initial begin
        int v [8];
        rst = 1'b1; in_valid = 1'b0; in_inv = 1'b0; in_a = '0; in_b = '0;
        repeat (3) @(posedge clk);
        #1;
        chk_eq("R8", int'(out_valid), 0);   // reset state
        rst = 1'b0;
        @(posedge clk); #1;

        // R5: latency and burst length of an isolated vector
        for (int n = 0; n < 8; n++) v[n] = (n == 2) ? 200 : 0;
        send_vec(1'b0, v, 1'b0, 1'b0);
        @(negedge clk); chk_eq("R5", int'(out_valid), 0);
        for (int c = 0; c < 4; c++) begin
            @(negedge clk); chk_eq("R5", int'(out_valid), 1);
        end
        @(negedge clk); chk_eq("R5", int'(out_valid), 0);
        @(posedge clk); #1;

        // R1 R2 R3 R4 R6 R7: sweep of patterns in both directions, back to back
        for (int md = 0; md < 2; md++) begin
            for (int t = 0; t < 170; t++) begin
                for (int n = 0; n < 8; n++) begin
                    if (t < 16)       v[n] = (n == t % 8) ? ((t < 8) ? 255 : -256) : 0;
                    else if (t == 16) v[n] = 255;
                    else if (t == 17) v[n] = -256;
                    else if (t == 18) v[n] = (n % 2 == 0) ? 255 : -256;
                    else if (t == 19) v[n] = n * 60 - 210;
                    else begin
                        lcg = lcg * 32'd1103515245 + 32'd12345;
                        v[n] = int'(lcg[24:16]) - 256;
                    end
                end
                // gaps exercise R6, flipped direction on later pairs exercises R7
                send_vec(md[0], v, (t % 5 == 3), (t % 7 == 2));
            end
        end
        repeat (12) @(posedge clk);
        #1;
        chk_eq("R6", rd0, wr);
        chk_eq("R6", rd1, wr);

        // R8: partial vector discarded by reset
        in_valid = 1'b1; in_inv = 1'b0; in_a = 9'sd100; in_b = 9'sd50;
        @(posedge clk); #1;
        in_a = -9'sd70; in_b = 9'sd20;
        @(posedge clk); #1;
        in_valid = 1'b0;
        rst = 1'b1;
        repeat (2) @(posedge clk);
        #1;
        rst = 1'b0;
        begin
            int seen = 0;
            for (int c = 0; c < 8; c++) begin
                @(negedge clk);
                if (out_valid) seen++;
            end
            chk_eq("R8", seen, 0);
        end
        @(posedge clk); #1;
        for (int n = 0; n < 8; n++) v[n] = 30 * n - 100;
        send_vec(1'b1, v, 1'b0, 1'b0);
        for (int n = 0; n < 8; n++) v[n] = (n < 4) ? 180 : -90;
        send_vec(1'b0, v, 1'b0, 1'b0);
        repeat (12) @(posedge clk);
        #1;
        chk_eq("R8", rd0, wr);
        chk_eq("R8", rd1, wr);

        done = 1'b1;
        summary();
        $finish;
    end
endmodule